// File: doc/BRIEF.md
# Asynchronous Transmit Modem-Handshake Controller

This block decides when an asynchronous character transmitter may put its first start bit on the line. It watches the transmit queue's not-empty flag and a free-running transmit bit clock. When data is waiting, it raises request-to-send (RTS) on a falling edge of that bit clock. It then counts whole bit times and pulses a start strobe to the character serializer once the clear-to-send (CTS) handshake allows it.

The wait after RTS depends on the CTS state. If CTS is already present at the edge where RTS rises, the wait is two bit times. If CTS arrives later, the wait counts from the bit-clock edge at which CTS is first seen. It is three bit times when the sampling-mode input is 0 and two when it is 1. If CTS goes away before the strobe, the count is thrown away and the block waits for CTS again. While characters are being sent, a transmit-gate output follows CTS so that the serializer can pause. A receive-gate output follows the carrier-detect (CD) input.

RTS stays high while the serializer is still busy or the queue still holds data. It falls on a bit-clock falling edge once both are done. All three line inputs (bit clock, CTS and CD) are asynchronous and pass through two-flop synchronizers.

Top module: `hs_modem_tx_ctrl`

## Requirements
- R1: `rts_out` rises only in the cycle range just after a falling edge of `bit_clk`, and only if `txq_nonempty` was high. While the queue is empty, `rts_out` stays low.
- R2: If `cts_in` is high at the bit-clock edge where RTS rises, `tx_start` pulses exactly 2 bit periods after the rise of `rts_out`.
- R3: If `cts_in` is low when RTS rises and `cts_after_mode` is 0, `tx_start` pulses exactly 3 bit periods after the bit-clock falling edge at which CTS is first sampled high.
- R4: If `cts_in` is low when RTS rises and `cts_after_mode` is 1, `tx_start` pulses exactly 2 bit periods after the edge at which CTS is first sampled high.
- R5: If CTS falls before `tx_start` has been issued, the bit count restarts. The strobe then follows the late-CTS rule of R3 or R4, counted from the edge where CTS is seen again.
- R6: `tx_start` is a one-cycle pulse. It is issued once per RTS session, only while `rts_out` is high, and it marks the first start bit.
- R7: After `tx_start`, `tx_gate` is high while the synchronized CTS is high and low while it is low. Outside a sending session `tx_gate` is low.
- R8: `rts_out` stays high while `ser_line_idle` is low or `txq_nonempty` is high. Once both allow it, `rts_out` falls on a bit-clock falling edge, a whole number of bit periods after it rose.
- R9: `rx_gate` follows `cd_in` three clock cycles later (two synchronizer flops and one output register).
- R10: While `rst_n` is low, `rts_out`, `tx_start`, `tx_gate` and `rx_gate` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txq_nonempty | input | 1 | Transmit queue holds data (system clock domain) |
| ser_line_idle | input | 1 | Serializer has finished the last stop bit |
| bit_clk | input | 1 | Transmit bit clock, asynchronous |
| cts_in | input | 1 | Clear-to-send, active high, asynchronous |
| cd_in | input | 1 | Carrier detect, active high, asynchronous |
| cts_after_mode | input | 1 | Selects the late-CTS latency: 0 gives 3 bit times, 1 gives 2 |
| rts_out | output | 1 | Request-to-send, active high |
| tx_start | output | 1 | One-cycle strobe: send the first start bit now |
| tx_gate | output | 1 | Transmission permitted during a sending session |
| rx_gate | output | 1 | Reception permitted (synchronized carrier detect) |

## Verification
The assertions assume that the bit clock is far slower than `clk`, so that each falling edge yields one isolated tick after synchronization. They also assume that `txq_nonempty` and `ser_line_idle` are driven synchronously to `clk`. The stimulus meets both conditions: the bit clock runs at 16 system clocks per period, and all queue and idle changes are driven on the falling system-clock edge. CTS changes only near the middle of a bit period, so the edge at which CTS is sampled is unambiguous. Each expected latency can then be stated as an exact number of bit periods.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_WAIT  = 2'd1,
    HS_COUNT = 2'd2,
    HS_SEND  = 2'd3
  } hs_state_e;

  localparam int unsigned HS_LAT_READY = 2;
  localparam int unsigned HS_LAT_SLOW  = 3;
  localparam int unsigned HS_LAT_FAST  = 2;
  localparam int unsigned HS_LAT_MAX   = 3;
endpackage

// File: rtl/hs_sync_bank.sv
module hs_sync_bank #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/hs_fall_detect.sv
module hs_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic fall_pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_in;
  end

  assign fall_pulse = prev_q & ~level_in;
endmodule

// File: rtl/hs_bit_counter.sv
module hs_bit_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = clr | inc;
    count_d  = clr ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cts_ok,
  input  logic             fifo_ne,
  input  logic             line_idle,
  input  logic             mode_fast,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             rts,
  output logic             start,
  output logic             gate
);
  hs_state_e        state_q, state_d;
  logic [CNT_W-1:0] tgt_q, tgt_d;
  logic             tgt_en;
  logic             rts_d, start_d, gate_d;
  logic [CNT_W:0]   cnt_next;

  localparam logic [CNT_W-1:0] TGT_READY = CNT_W'(HS_LAT_READY);
  localparam logic [CNT_W-1:0] TGT_SLOW  = CNT_W'(HS_LAT_SLOW);
  localparam logic [CNT_W-1:0] TGT_FAST  = CNT_W'(HS_LAT_FAST);

  assign cnt_next = {1'b0, cnt} + 1'b1;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    tgt_en  = 1'b0;
    rts_d   = rts;
    start_d = 1'b0;
    gate_d  = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if (tick && fifo_ne) begin
          rts_d   = 1'b1;
          cnt_clr = 1'b1;
          if (cts_ok) begin
            state_d = HS_COUNT;
            tgt_d   = TGT_READY;
            tgt_en  = 1'b1;
          end else begin
            state_d = HS_WAIT;
          end
        end
      end
      HS_WAIT: begin
        if (tick && cts_ok) begin
          state_d = HS_COUNT;
          tgt_d   = mode_fast ? TGT_FAST : TGT_SLOW;
          tgt_en  = 1'b1;
          cnt_clr = 1'b1;
        end
      end
      HS_COUNT: begin
        if (!cts_ok) begin
          state_d = HS_WAIT;
          cnt_clr = 1'b1;
        end else if (tick) begin
          if (cnt_next >= {1'b0, tgt_q}) begin
            state_d = HS_SEND;
            start_d = 1'b1;
            gate_d  = 1'b1;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      HS_SEND: begin
        gate_d = cts_ok;
        if (tick && line_idle && !fifo_ne) begin
          state_d = HS_IDLE;
          rts_d   = 1'b0;
          gate_d  = 1'b0;
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      rts     <= 1'b0;
      start   <= 1'b0;
      gate    <= 1'b0;
    end else begin
      state_q <= state_d;
      rts     <= rts_d;
      start   <= start_d;
      gate    <= gate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_en) tgt_q <= tgt_d;
  end
endmodule

// File: rtl/hs_modem_tx_ctrl.sv
module hs_modem_tx_ctrl
  import hs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txq_nonempty,
  input  logic ser_line_idle,
  input  logic bit_clk,
  input  logic cts_in,
  input  logic cd_in,
  input  logic cts_after_mode,
  output logic rts_out,
  output logic tx_start,
  output logic tx_gate,
  output logic rx_gate
);
  localparam int unsigned N_SYNC = 3;
  localparam int unsigned CNT_W  = $clog2(HS_LAT_MAX + 1);

  logic [N_SYNC-1:0] raw_lines, synced_lines;
  logic              bclk_s, cts_s, cd_s;
  logic              fall_tick;
  logic              cnt_clr, cnt_inc;
  logic [CNT_W-1:0]  cnt;

  assign raw_lines = {cd_in, cts_in, bit_clk};
  assign {cd_s, cts_s, bclk_s} = synced_lines;

  hs_sync_bank #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(raw_lines), .sync_out(synced_lines)
  );

  hs_fall_detect edge_i (
    .clk(clk), .rst_n(rst_n), .level_in(bclk_s), .fall_pulse(fall_tick)
  );

  hs_bit_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .count(cnt)
  );

  hs_seq_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .tick(fall_tick), .cts_ok(cts_s),
    .fifo_ne(txq_nonempty), .line_idle(ser_line_idle),
    .mode_fast(cts_after_mode), .cnt(cnt), .cnt_clr(cnt_clr),
    .cnt_inc(cnt_inc), .rts(rts_out), .start(tx_start), .gate(tx_gate)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_gate <= 1'b0;
    else        rx_gate <= cd_s;
  end
endmodule

// File: rtl/hs_modem_tx_ctrl_chk.sv
module hs_modem_tx_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic txq_nonempty,
  input logic ser_line_idle,
  input logic fall_tick,
  input logic cts_s,
  input logic rts_out,
  input logic tx_start,
  input logic tx_gate
);
  // R1: RTS rises only after a bit-clock tick with data queued
  p_rts_rise_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_out) |-> $past(fall_tick) && $past(txq_nonempty));

  // R8: RTS falls only after a tick, with the queue empty and the line idle
  p_rts_fall_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_out) |-> $past(fall_tick) && $past(ser_line_idle) && !$past(txq_nonempty));

  // R6: single-cycle strobe, only under RTS
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  p_start_rts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> rts_out);

  // R5: strobe needs CTS present at the tick that issues it
  p_start_cts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(cts_s) && $past(fall_tick));

  // R7: gate implies an open session and CTS present
  p_gate_cts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_gate |-> rts_out && $past(cts_s));
endmodule

bind hs_modem_tx_ctrl hs_modem_tx_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .txq_nonempty(txq_nonempty),
  .ser_line_idle(ser_line_idle), .fall_tick(fall_tick), .cts_s(cts_s),
  .rts_out(rts_out), .tx_start(tx_start), .tx_gate(tx_gate)
);

// File: tb/hs_modem_tx_ctrl_tb_top.sv
`timescale 1ns/1ps
module hs_modem_tx_ctrl_tb_top;
  localparam int HALF = 8;
  localparam int P    = 2 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txq_nonempty = 1'b0, ser_line_idle = 1'b1, bit_clk = 1'b1;
  logic cts_in = 1'b0, cd_in = 1'b0, cts_after_mode = 1'b0;
  logic rts_out, tx_start, tx_gate, rx_gate;

  int total = 0, bad = 0;
  int cyc = 0, div = 0;
  int last_fall = 0;
  int t_rts = 0, t_rts_fall = 0, t_start = 0;
  int starts = 0;
  logic prev_rts = 1'b0;
  logic [31:0] seed_v;

  always #2.5 clk = ~clk;

  hs_modem_tx_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .txq_nonempty(txq_nonempty),
    .ser_line_idle(ser_line_idle), .bit_clk(bit_clk), .cts_in(cts_in),
    .cd_in(cd_in), .cts_after_mode(cts_after_mode), .rts_out(rts_out),
    .tx_start(tx_start), .tx_gate(tx_gate), .rx_gate(rx_gate)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (div == HALF - 1) begin
      div = 0;
      if (bit_clk) last_fall = cyc;
      bit_clk = ~bit_clk;
    end else begin
      div = div + 1;
    end
    if (rts_out && !prev_rts) t_rts = cyc;
    if (!rts_out && prev_rts) t_rts_fall = cyc;
    if (tx_start) begin t_start = cyc; starts = starts + 1; end
    prev_rts = rts_out;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_edges(input int seen_edge, input bit fast);
    if (seen_edge == 0) return 2;
    return seen_edge + (fast ? 2 : 3);
  endfunction

  task automatic to_mid();
    @(negedge bit_clk);
    repeat (HALF) @(negedge clk);
  endtask

  task automatic session(input int m, input bit fast, input bit drop, input bit gate_test);
    int s0, exp, w, seen;
    cts_in = (m == 0);
    cts_after_mode = fast;
    repeat (2 * P) @(negedge clk);
    check("R1 rts low while queue empty", rts_out, 0);
    s0 = starts;
    to_mid();
    txq_nonempty = 1'b1;
    w = 0;
    while (!rts_out && w < 4 * P) begin @(negedge clk); w++; end
    @(negedge clk);
    check("R1 rts rises just after a bit-clock fall", int'((t_rts - last_fall) <= 6 && (t_rts - last_fall) >= 1), 1);
    if (drop) begin
      to_mid(); cts_in = 1'b0;
      to_mid(); cts_in = 1'b1;
      seen = 3;
    end else if (m > 0) begin
      repeat (m - 1) @(negedge bit_clk);
      repeat (HALF) @(negedge clk);
      cts_in = 1'b1;
      seen = m;
    end else begin
      seen = 0;
    end
    exp = drop ? 3 + (fast ? 2 : 3) : exp_edges(seen, fast);
    w = 0;
    while (starts == s0 && w < 10 * P) begin @(negedge clk); w++; end
    ser_line_idle = 1'b0;
    if (drop)           check("R5 restart after CTS drop", t_start - t_rts, exp * P);
    else if (m == 0)    check("R2 CTS ready latency", t_start - t_rts, exp * P);
    else if (fast)      check("R4 late CTS fast latency", t_start - t_rts, exp * P);
    else                check("R3 late CTS slow latency", t_start - t_rts, exp * P);
    @(negedge clk);
    check("R6 strobe is one cycle", tx_start, 0);
    check("R7 gate open after start", tx_gate, 1);
    repeat (2 * P) @(negedge clk);
    check("R8 rts held while serializer busy", rts_out, 1);
    check("R6 single strobe per session", starts - s0, 1);
    if (gate_test) begin
      cts_in = 1'b0;
      repeat (5) @(negedge clk);
      check("R7 gate follows CTS low", tx_gate, 0);
      cts_in = 1'b1;
      repeat (5) @(negedge clk);
      check("R7 gate follows CTS high", tx_gate, 1);
    end
    to_mid();
    txq_nonempty = 1'b0;
    ser_line_idle = 1'b1;
    w = 0;
    while (rts_out && w < 3 * P) begin @(negedge clk); w++; end
    @(negedge clk);
    check("R8 rts drops on a bit-clock fall", int'(!rts_out && ((t_rts_fall - t_rts) % P == 0)), 1);
    check("R7 gate closed after session", tx_gate, 0);
    check("R6 no strobe after session", starts - s0, 1);
  endtask

  initial begin
    seed_v = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    check("R10 rts in reset", rts_out, 0);
    check("R10 start in reset", tx_start, 0);
    check("R10 gate in reset", tx_gate, 0);
    check("R10 rx gate in reset", rx_gate, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cd_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 rx gate not yet", rx_gate, 0);
    @(negedge clk);
    check("R9 rx gate follows CD", rx_gate, 1);
    cd_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 rx gate drops with CD", rx_gate, 0);
    session(0, 1'b0, 1'b0, 1'b1);
    session(1, 1'b0, 1'b0, 1'b0);
    session(1, 1'b1, 1'b0, 1'b0);
    session(4, 1'b0, 1'b0, 1'b1);
    session(0, 1'b0, 1'b1, 1'b0);
    session(0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) begin
      int m;
      bit f, g;
      m = int'($urandom_range(0, 4));
      f = 1'(($urandom() >> 3) & 1);
      g = 1'(($urandom() >> 5) & 1);
      session(m, f, 1'b0, g);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule